// File: doc/BRIEF.md
# Multichannel Driver Fault Supervisor

This block collects the fault events of a multichannel low-side load-switch controller and turns them into per-channel fault bits, an active-low fault line meant for an open-drain pad, a per-channel disable vector for the gate drive, and a request to hold the serial data output low after a bad serial frame. The analog sensing, current limiting, serial shifter and gate drivers sit outside; they feed this block with set and clear flags and single-cycle pulses in the system clock domain.

After power-up or after the supply returns from undervoltage, the fault line is held low for a fixed masking interval. An inrush timer runs from the same point; it stops counting while any overtemperature flag is active. Until it has run out, a channel overtemperature is tolerated silently. A die overtemperature faults every channel at any time. With cut-off delay protection enabled, a channel's delay-expiry pulse faults that channel for a fixed retry interval, after which the fault clears by itself. A serial frame error is reported only through the data-output request, never through the fault line.

Top module: `drv_fault_supervisor`

## Requirements
- R1: After reset release, and after `uv` falls, `fault_n` is low for exactly VALID_CYC cycles regardless of the fault bits.
- R2: The inrush timer advances one step per cycle from the end of reset or undervoltage, and stands still in any cycle in which a channel or die overtemperature flag is held; it finishes after INRUSH_CYC advancing cycles.
- R3: A held channel overtemperature flag does not set that channel's fault bit while the inrush timer has not finished.
- R4: A held channel overtemperature flag after the inrush timer has finished sets only that channel's fault bit, from the cycle after `ch_ot_set` bit i is pulsed.
- R5: A held die overtemperature flag sets every fault bit from the cycle after `die_ot_set`, whether or not the inrush timer has finished.
- R6: Each overtemperature flag is set by its set pulse and held until its clear pulse; when both arrive in the same cycle the set wins.
- R7: With `cod_en` high, a pulse on `cod_exp` bit i sets fault bit i for exactly RETRY_CYC cycles, then it clears by itself; a new pulse while it is set restarts the interval; with `cod_en` low the pulse has no effect.
- R8: A pulse on `spi_err` raises `sdo_low_req` from the next cycle until the cycle after a `spi_frame_ok` pulse; if both arrive together the error wins; neither touches the fault bits or `fault_n`.
- R9: While `uv` is high, all state is cleared in the cycle it is seen, `fault_bits` reads 0, `fault_n` is high, `ch_dis` is all ones and `sdo_low_req` is 0.
- R10: Outside undervoltage, `ch_dis` bit i equals `fault_bits` bit i in every cycle, releasing in the same cycle the bit clears.
- R11: Outside undervoltage and after the mask of R1, `fault_n` is low exactly when at least one fault bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv | input | 1 | Supply undervoltage flag, high while below threshold |
| ch_ot_set | input | NCH | Per-channel overtemperature assert pulses |
| ch_ot_clr | input | NCH | Per-channel overtemperature clear pulses (below threshold minus hysteresis) |
| die_ot_set | input | 1 | Die overtemperature assert pulse |
| die_ot_clr | input | 1 | Die overtemperature clear pulse |
| cod_en | input | 1 | Cut-off delay protection enable |
| cod_exp | input | NCH | Per-channel cut-off delay expiry pulses |
| spi_err | input | 1 | Serial frame error pulse |
| spi_frame_ok | input | 1 | Valid serial frame pulse |
| fault_bits | output | NCH | Per-channel fault bits |
| fault_n | output | 1 | Active-low combined fault line |
| ch_dis | output | NCH | Per-channel disable to the gate drive |
| sdo_low_req | output | 1 | Hold serial data output low while the clock is high |

## Verification
The collisions that matter here are a retry interval running out in the very cycle another source raises the same channel's bit, and a set pulse meeting a clear pulse on one overtemperature flag, together with a serial error landing on the cycle a cut-off expiry arrives. The bench provokes these by placing the pulses on chosen cycles against a behavioural model that tracks the timers as plain integers, and every output is compared against that model on every clock, so a cycle where one event masks or swallows the other shows up as a mismatch at the exact cycle.

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor #(
  parameter int NCH        = 4,
  parameter int VALID_CYC  = 64,
  parameter int INRUSH_CYC = 1000,
  parameter int RETRY_CYC  = 500
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           uv,
  input  logic [NCH-1:0] ch_ot_set,
  input  logic [NCH-1:0] ch_ot_clr,
  input  logic           die_ot_set,
  input  logic           die_ot_clr,
  input  logic           cod_en,
  input  logic [NCH-1:0] cod_exp,
  input  logic           spi_err,
  input  logic           spi_frame_ok,
  output logic [NCH-1:0] fault_bits,
  output logic           fault_n,
  output logic [NCH-1:0] ch_dis,
  output logic           sdo_low_req
);

  localparam int VW = $clog2(VALID_CYC + 1);
  localparam int IW = $clog2(INRUSH_CYC + 1);
  localparam int RW = $clog2(RETRY_CYC + 1);
  localparam logic [VW-1:0] VALID_END  = VW'(VALID_CYC);
  localparam logic [IW-1:0] INRUSH_END = IW'(INRUSH_CYC);
  localparam logic [RW-1:0] RETRY_LD   = RW'(RETRY_CYC);

  logic [VW-1:0]  mask_cnt;
  logic [IW-1:0]  inr_cnt;
  logic [NCH-1:0] ch_ot, cod_flt;
  logic           die_ot, sdo_q;
  logic [RW-1:0]  rcnt [NCH];

  wire masking   = mask_cnt != VALID_END;
  wire inr_done  = inr_cnt == INRUSH_END;
  wire ot_held   = (|ch_ot) | die_ot;
  wire [NCH-1:0] raw_bits = ({NCH{inr_done}} & ch_ot) | {NCH{die_ot}} | cod_flt;

  assign fault_bits  = uv ? '0 : raw_bits;
  assign fault_n     = uv | ~(masking | (|raw_bits));
  assign ch_dis      = uv ? '1 : raw_bits;
  assign sdo_low_req = sdo_q & ~uv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_cnt <= '0;
      inr_cnt  <= '0;
      ch_ot    <= '0;
      die_ot   <= 1'b0;
      sdo_q    <= 1'b0;
    end else if (uv) begin
      mask_cnt <= '0;
      inr_cnt  <= '0;
      ch_ot    <= '0;
      die_ot   <= 1'b0;
      sdo_q    <= 1'b0;
    end else begin
      if (masking) mask_cnt <= mask_cnt + VW'(1);
      if (!inr_done && !ot_held) inr_cnt <= inr_cnt + IW'(1);
      ch_ot  <= ch_ot_set | (ch_ot & ~ch_ot_clr);
      die_ot <= die_ot_set | (die_ot & ~die_ot_clr);
      sdo_q  <= spi_err | (sdo_q & ~spi_frame_ok);
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_retry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cod_flt[i] <= 1'b0;
        rcnt[i]    <= '0;
      end else if (uv) begin
        cod_flt[i] <= 1'b0;
        rcnt[i]    <= '0;
      end else if (cod_en && cod_exp[i]) begin
        cod_flt[i] <= 1'b1;
        rcnt[i]    <= RETRY_LD;
      end else if (cod_flt[i]) begin
        if (rcnt[i] == RW'(1)) cod_flt[i] <= 1'b0;
        rcnt[i] <= rcnt[i] - RW'(1);
      end
    end
  end

  assert_mask_after_uv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uv) |-> !fault_n);

  assert_inrush_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv && ot_held) |=> (inr_cnt == $past(inr_cnt)) || uv);

  assert_die_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (die_ot_set && !uv) |=> (&fault_bits) || uv);

  assert_cod_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cod_en && (|cod_exp) && !uv) |=> ((fault_bits & $past(cod_exp)) == $past(cod_exp)) || uv);

  assert_spi_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_err && !uv) |=> sdo_low_req || uv);

  assert_spi_ok_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_frame_ok && !spi_err) |=> !sdo_low_req);

endmodule

// File: tb/tb_drv_fault_supervisor.sv
module tb_drv_fault_supervisor;
  localparam int NCH = 4, VC = 8, IC = 24, RC = 10;

  logic clk = 1'b0, rst_n = 1'b0, uv = 1'b0;
  logic [NCH-1:0] ch_ot_set = '0, ch_ot_clr = '0, cod_exp = '0;
  logic die_ot_set = 1'b0, die_ot_clr = 1'b0, cod_en = 1'b0;
  logic spi_err = 1'b0, spi_frame_ok = 1'b0;
  logic [NCH-1:0] fault_bits, ch_dis;
  logic fault_n, sdo_low_req;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  drv_fault_supervisor #(.NCH(NCH), .VALID_CYC(VC), .INRUSH_CYC(IC), .RETRY_CYC(RC)) dut (
    .clk(clk), .rst_n(rst_n), .uv(uv), .ch_ot_set(ch_ot_set), .ch_ot_clr(ch_ot_clr),
    .die_ot_set(die_ot_set), .die_ot_clr(die_ot_clr), .cod_en(cod_en), .cod_exp(cod_exp),
    .spi_err(spi_err), .spi_frame_ok(spi_frame_ok), .fault_bits(fault_bits),
    .fault_n(fault_n), .ch_dis(ch_dis), .sdo_low_req(sdo_low_req));

  always #2.5 clk = ~clk;

  // behavioural reference
  int m_mask, m_inr;
  int m_rc [NCH];
  bit m_cot [NCH];
  bit m_cod [NCH];
  bit m_dot, m_sdo;

  task automatic m_clear();
    m_mask = 0; m_inr = 0; m_dot = 0; m_sdo = 0;
    for (int i = 0; i < NCH; i++) begin m_cot[i] = 0; m_cod[i] = 0; m_rc[i] = 0; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || uv) m_clear();
    else begin
      bit any_ot;
      any_ot = m_dot;
      for (int i = 0; i < NCH; i++) any_ot |= m_cot[i];
      if (m_mask < VC) m_mask++;
      if (m_inr < IC && !any_ot) m_inr++;
      for (int i = 0; i < NCH; i++) begin
        if (ch_ot_set[i]) m_cot[i] = 1; else if (ch_ot_clr[i]) m_cot[i] = 0;
        if (cod_en && cod_exp[i]) begin m_cod[i] = 1; m_rc[i] = RC; end
        else if (m_cod[i]) begin
          if (m_rc[i] == 1) m_cod[i] = 0;
          m_rc[i]--;
        end
      end
      if (die_ot_set) m_dot = 1; else if (die_ot_clr) m_dot = 0;
      if (spi_err) m_sdo = 1; else if (spi_frame_ok) m_sdo = 0;
    end
  end

  string phase = "reset";

  always @(negedge clk) begin
    logic [NCH-1:0] eb, ed;
    logic en, es;
    for (int i = 0; i < NCH; i++)
      eb[i] = !uv && ((m_cot[i] && m_inr == IC) || m_dot || m_cod[i]);
    en = uv || !((m_mask < VC) || (|eb));
    ed = uv ? '1 : eb;
    es = m_sdo && !uv;
    n_cmp++;
    if (fault_bits !== eb) begin
      n_bad++;
      $display("FAIL R3/R4/R5/R6/R7 [%s] t=%0t fault_bits=%b expected %b", phase, $time, fault_bits, eb);
    end
    n_cmp++;
    if (fault_n !== en) begin
      n_bad++;
      $display("FAIL R1/R11 [%s] t=%0t fault_n=%b expected %b", phase, $time, fault_n, en);
    end
    n_cmp++;
    if (ch_dis !== ed) begin
      n_bad++;
      $display("FAIL R9/R10 [%s] t=%0t ch_dis=%b expected %b", phase, $time, ch_dis, ed);
    end
    n_cmp++;
    if (sdo_low_req !== es) begin
      n_bad++;
      $display("FAIL R8 [%s] t=%0t sdo_low_req=%b expected %b", phase, $time, sdo_low_req, es);
    end
  end

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      ch_ot_set = '0; ch_ot_clr = '0; cod_exp = '0;
      die_ot_set = 0; die_ot_clr = 0; spi_err = 0; spi_frame_ok = 0;
    end
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    phase = "R1 power-up mask"; tick(4);
    phase = "R2 R3 channel OT in inrush"; ch_ot_set[1] = 1; tick(40);
    ch_ot_clr[1] = 1; tick(30);
    phase = "R4 R11 channel OT after inrush"; ch_ot_set[2] = 1; tick(5);
    phase = "R6 set beats clear"; ch_ot_set[2] = 1; ch_ot_clr[2] = 1; tick(3);
    ch_ot_clr[2] = 1; tick(3);
    phase = "R7 COD retry"; cod_en = 1; cod_exp[0] = 1; tick(4);
    cod_exp[0] = 1; tick(RC + 3);
    phase = "R7 COD disabled"; cod_en = 0; cod_exp[3] = 1; tick(3);
    phase = "R8 SPI error"; spi_err = 1; tick(3);
    spi_frame_ok = 1; tick(2);
    spi_err = 1; spi_frame_ok = 1; tick(2);
    spi_frame_ok = 1; tick(2);
    phase = "R10 collision COD end vs OT"; cod_en = 1; cod_exp[1] = 1; spi_err = 1; tick(RC - 1);
    ch_ot_set[1] = 1; tick(4);
    ch_ot_clr[1] = 1; cod_exp[1] = 1; tick(RC + 2);
    spi_frame_ok = 1; tick(2);
    phase = "R9 undervoltage"; cod_exp[2] = 1; spi_err = 1; tick(2);
    uv = 1; tick(3);
    uv = 0;
    phase = "R5 die OT in inrush"; die_ot_set = 1; tick(5);
    ch_ot_set[3] = 1; tick(5);
    die_ot_clr = 1; tick(30);
    ch_ot_clr[3] = 1; tick(40);
    phase = "R5 die OT after inrush"; die_ot_set = 1; die_ot_clr = 1; tick(4);
    die_ot_clr = 1; tick(VC + 4);
    phase = "R9 uv mid-fault"; cod_exp[0] = 1; ch_ot_set[0] = 1; tick(3);
    uv = 1; tick(2); uv = 0; tick(VC + 5);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule